// File: doc/BRIEF.md
# Autoranging Prescale and Gate Controller

This block decides how a frequency counter's count engine is set up. It picks the power-of-two input divide ratio, which is a division code from 0 to 4 giving N = 2^code. It also sets the length of the gate interval. It then tells the engine when to start. Every run of measurements begins with a short probe. The probe is taken at the coarsest divide ratio and with a gate one eighth of the normal length. From the probe count the block projects the count that each divide ratio would give over a full gate. It then picks the finest ratio that keeps this projection under the upper threshold. A slow input therefore gets a small divide factor and still builds up enough counts in a fixed update period. The gate time never has to grow.

After the probe, every full-gate measurement is reported as the raw count shifted left by the division code. Between measurements the range moves by hysteresis. A count near the top of the counter's scale moves the range one divide step coarser. A count near the bottom moves it one step finer. The range never moves more than one step at a time. Results taken on a range that has just been selected are marked as not trustworthy.

The count engine sits outside this block. It counts divided input edges while the gate output is high. Some time after the gate closes it returns the count with a one-cycle done pulse.

Top module: `autorange_ctrl`

## Requirements
- R1: While reset is low, start_o, gate_o and res_stb_o are 0 and div_code_o is 4, the coarsest ratio, N = 16.
- R2: The first measurement after reset is a probe. It uses div_code_o = 4 and gate_len_o = GATE_CYC/8, which is 8 by default, and no res_stb_o pulse follows it.
- R3: After the probe, div_code_o becomes the smallest code k in 0..4 for which (probe count × 8 × 16) / 2^k ≤ 3584. If no code qualifies it becomes 4.
- R4: After a full measurement with count c, the code rises by one if c > 3584 (7/8 of 4096) and falls by one if c < 512 (1/8 of 4096). Otherwise it is unchanged. The code is clamped to 0..4 and never moves more than one step per measurement.
- R5: One cycle after an accepted done of a full measurement, res_stb_o is high for exactly one cycle, and res_val_o = count << (the code used for that measurement).
- R6: res_ok_o is 0 for the first full measurement after the probe and for the first measurement after any code change. Otherwise it is 1.
- R7: start_o is a one-cycle pulse. gate_o rises in the same cycle and stays high for exactly gate_len_o cycles, and div_code_o stays stable while the gate is open. Full measurements use gate_len_o = GATE_CYC, which is 64 by default.
- R8: A done_i pulse while gate_o is high is ignored. It produces no result and no range change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done_i | input | 1 | Count engine finished, count_i valid |
| count_i | input | CNT_W | Raw count of divided input edges |
| start_o | output | 1 | One-cycle start strobe to the count engine |
| gate_o | output | 1 | Gate window, high while the engine counts |
| gate_len_o | output | GATE_W | Gate length in clock cycles for this measurement |
| div_code_o | output | CODE_W | Divide code, N = 2^code |
| res_stb_o | output | 1 | Result strobe |
| res_val_o | output | RES_W | Count scaled back by N |
| res_ok_o | output | 1 | Result taken on a settled range |

## Verification
The bench aims at the hysteresis edges: counts of exactly 3584 and 512 must hold the range, while 3585 and 511 must move it. A design that used the wrong comparison would step one measurement early or late, and the shifted result of the following measurement would come out twice or half as large. The bench also clamps the range at both ends. A design without clamping would wrap from 4 to 5 or from 0 to 7, which shows up as a wrong code and a wrong shift. For the probe, the bench uses counts at the projection boundary (28 against 29) and checks that res_ok_o is low after every range change. A spurious done pulse placed inside the gate must leave both the code and the result untouched.

// File: rtl/afr_pkg.sv
// Shared types for the autoranging controller.
// Assumes: two-state sequencing, launch then wait for the engine.
package afr_pkg;
    typedef enum logic [0:0] {
        ST_LAUNCH = 1'b0,
        ST_WAIT   = 1'b1
    } afr_state_t;
endpackage

// File: rtl/afr_gate_timer.sv
// Gate window timer: loads a length and holds gate_o high for that many
// cycles, starting in the cycle after the load edge.
// Assumes: load is only applied while the gate is closed; len_i > 0.
module afr_gate_timer #(
    parameter int GATE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [GATE_W-1:0] len_i,
    output logic              gate_o
);
    logic [GATE_W-1:0] remain_q;

    // Down-count the open gate window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain_q <= '0;
        else if (load_i)
            remain_q <= len_i;
        else if (remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    assign gate_o = (remain_q != '0);
endmodule

// File: rtl/afr_range_pick.sv
// Next divide code: a projection-based pick after a probe, or a single
// hysteresis step after a full measurement.
// Assumes: the probe runs at code MAX_CODE with a gate shortened by 2^PROBE_SHIFT.
module afr_range_pick #(
    parameter int CNT_W       = 12,
    parameter int MAX_CODE    = 4,
    parameter int PROBE_SHIFT = 3,
    parameter int CODE_W      = 3
) (
    input  logic              probe_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CODE_W-1:0] cur_code_i,
    output logic [CODE_W-1:0] next_code_o
);
    localparam int PROJ_W = CNT_W + PROBE_SHIFT + MAX_CODE;
    localparam logic [CNT_W-1:0] HI_TH = CNT_W'(7 << (CNT_W - 3));
    localparam logic [CNT_W-1:0] LO_TH = CNT_W'(1 << (CNT_W - 3));
    localparam logic [CODE_W-1:0] TOP  = CODE_W'(MAX_CODE);

    logic [PROJ_W-1:0] proj [MAX_CODE+1];
    logic [CODE_W-1:0] pick;
    logic [CODE_W-1:0] step;

    // Projected full-gate count for each candidate code.
    for (genvar k = 0; k <= MAX_CODE; k++) begin : g_proj
        assign proj[k] = PROJ_W'(count_i) << (PROBE_SHIFT + MAX_CODE - k);
    end

    // Smallest code whose projection stays at or under the upper threshold.
    always_comb begin
        pick = TOP;
        for (int k = MAX_CODE; k >= 0; k--) begin
            if (proj[k] <= PROJ_W'(HI_TH))
                pick = CODE_W'(k);
        end
    end

    // One hysteresis step, clamped at both ends.
    always_comb begin
        step = cur_code_i;
        if (count_i > HI_TH && cur_code_i != TOP)
            step = cur_code_i + 1'b1;
        else if (count_i < LO_TH && cur_code_i != '0)
            step = cur_code_i - 1'b1;
    end

    assign next_code_o = probe_i ? pick : step;
endmodule

// File: rtl/afr_scaler.sv
// Scales a raw count back to undivided units with a left shift by the code.
// Assumes: code never exceeds MAX_CODE, so RES_W holds the result.
module afr_scaler #(
    parameter int CNT_W    = 12,
    parameter int MAX_CODE = 4,
    parameter int CODE_W   = 3,
    parameter int RES_W    = 16
) (
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [RES_W-1:0]  scaled_o
);
    assign scaled_o = RES_W'(count_i) << code_i;
endmodule

// File: rtl/autorange_ctrl.sv
// Autoranging controller: runs a probe, picks a divide code, launches
// full-gate measurements, scales results and steps the range by hysteresis.
// Assumes: the engine answers each start with one done pulse after the gate closes.
module autorange_ctrl #(
    parameter int CNT_W       = 12,
    parameter int MAX_CODE    = 4,
    parameter int GATE_CYC    = 64,
    parameter int PROBE_SHIFT = 3,
    localparam int CODE_W     = $clog2(MAX_CODE + 1),
    localparam int GATE_W     = $clog2(GATE_CYC + 1),
    localparam int RES_W      = CNT_W + MAX_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              start_o,
    output logic              gate_o,
    output logic [GATE_W-1:0] gate_len_o,
    output logic [CODE_W-1:0] div_code_o,
    output logic              res_stb_o,
    output logic [RES_W-1:0]  res_val_o,
    output logic              res_ok_o
);
    import afr_pkg::*;

    localparam logic [GATE_W-1:0] FULL_LEN  = GATE_W'(GATE_CYC);
    localparam logic [GATE_W-1:0] PROBE_LEN = GATE_W'(GATE_CYC >> PROBE_SHIFT);

    afr_state_t        state_q;
    logic              probing_q;
    logic              fresh_q;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] next_code;
    logic [RES_W-1:0]  scaled;
    logic              launch;
    logic              accept;

    assign launch     = (state_q == ST_LAUNCH);
    assign accept     = (state_q == ST_WAIT) && done_i && !gate_o;
    assign gate_len_o = probing_q ? PROBE_LEN : FULL_LEN;
    assign div_code_o = code_q;

    afr_gate_timer #(.GATE_W(GATE_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (launch),
        .len_i  (gate_len_o),
        .gate_o (gate_o)
    );

    afr_range_pick #(
        .CNT_W(CNT_W), .MAX_CODE(MAX_CODE),
        .PROBE_SHIFT(PROBE_SHIFT), .CODE_W(CODE_W)
    ) pick_i (
        .probe_i     (probing_q),
        .count_i     (count_i),
        .cur_code_i  (code_q),
        .next_code_o (next_code)
    );

    afr_scaler #(
        .CNT_W(CNT_W), .MAX_CODE(MAX_CODE), .CODE_W(CODE_W), .RES_W(RES_W)
    ) scale_i (
        .count_i  (count_i),
        .code_i   (code_q),
        .scaled_o (scaled)
    );

    // Sequencing: launch, wait for done, update the range and publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_LAUNCH;
            probing_q <= 1'b1;
            fresh_q   <= 1'b1;
            code_q    <= CODE_W'(MAX_CODE);
            start_o   <= 1'b0;
            res_stb_o <= 1'b0;
            res_val_o <= '0;
            res_ok_o  <= 1'b0;
        end else begin
            start_o   <= launch;
            res_stb_o <= 1'b0;
            case (state_q)
                ST_LAUNCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (accept) begin
                        state_q <= ST_LAUNCH;
                        code_q  <= next_code;
                        if (probing_q) begin
                            probing_q <= 1'b0;
                            fresh_q   <= 1'b1;
                        end else begin
                            res_stb_o <= 1'b1;
                            res_val_o <= scaled;
                            res_ok_o  <= !fresh_q;
                            fresh_q   <= (next_code != code_q);
                        end
                    end
                end
                default: state_q <= ST_LAUNCH;
            endcase
        end
    end
endmodule

// File: rtl/autorange_ctrl_chk.sv
// Property checker for autorange_ctrl, attached by bind.
// Assumes: observes top-level ports only.
module autorange_ctrl_chk #(
    parameter int CODE_W   = 3,
    parameter int RES_W    = 16,
    parameter int MAX_CODE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_o,
    input logic              gate_o,
    input logic [CODE_W-1:0] div_code_o,
    input logic              res_stb_o,
    input logic [RES_W-1:0]  res_val_o
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);                                           // R7
    AST_START_OPENS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> gate_o);                                             // R7
    AST_CODE_HELD_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && !start_o) |-> $stable(div_code_o));                   // R7
    AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_code_o <= CODE_W'(MAX_CODE));                                // R4
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        res_stb_o |-> (div_code_o == $past(div_code_o) ||
                       div_code_o == $past(div_code_o) + 1'b1 ||
                       div_code_o + 1'b1 == $past(div_code_o)));         // R4
    AST_SHIFT_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        res_stb_o |-> ((res_val_o & ((RES_W'(1) << $past(div_code_o)) - 1'b1)) == '0)); // R5
    AST_NO_RESULT_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> !res_stb_o);                                          // R8
endmodule

bind autorange_ctrl autorange_ctrl_chk #(
    .CODE_W(CODE_W), .RES_W(RES_W), .MAX_CODE(MAX_CODE)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_o    (start_o),
    .gate_o     (gate_o),
    .div_code_o (div_code_o),
    .res_stb_o  (res_stb_o),
    .res_val_o  (res_val_o)
);

// File: tb/autorange_ctrl_tb_top.sv
// Bench: acts as the count engine, drives directed and random counts, and
// checks the code, gate, result and flag against a bench model.
module autorange_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_i = 1'b0;
    logic [11:0] count_i = '0;
    logic        start_o, gate_o, res_stb_o, res_ok_o;
    logic [6:0]  gate_len_o;
    logic [2:0]  div_code_o;
    logic [15:0] res_val_o;

    int checks = 0;
    int errors = 0;
    int exp_code;
    bit exp_ok;
    int seen_code, seen_len, seen_gl;
    bit stb_in_gate;

    always #10 clk = ~clk;

    autorange_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .count_i(count_i),
        .start_o(start_o), .gate_o(gate_o), .gate_len_o(gate_len_o),
        .div_code_o(div_code_o), .res_stb_o(res_stb_o),
        .res_val_o(res_val_o), .res_ok_o(res_ok_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_pick(input int cp);
        for (int k = 0; k <= 4; k++)
            if (((cp * 128) >> k) <= 3584) return k;
        return 4;
    endfunction

    function automatic int model_step(input int code, input int c);
        if (c > 3584 && code < 4) return code + 1;
        if (c < 512 && code > 0) return code - 1;
        return code;
    endfunction

    // Count engine: wait for start, follow the gate, then answer with done.
    task automatic engine(input int c, input bit glitch);
        int gl;
        while (!start_o) @(negedge clk);
        seen_code = div_code_o;
        seen_len = gate_len_o;
        gl = 0;
        stb_in_gate = 0;
        while (gate_o) begin
            gl++;
            if (res_stb_o) stb_in_gate = 1;
            done_i = glitch && (gl == 2);
            count_i = 12'hFFF;
            @(negedge clk);
        end
        done_i = 0;
        seen_gl = gl;
        @(negedge clk);
        done_i = 1;
        count_i = 12'(c);
        @(negedge clk);
        done_i = 0;
    endtask

    task automatic do_reset;
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk(start_o == 0 && gate_o == 0 && res_stb_o == 0, "R1 outputs idle", start_o, 0);
        chk(div_code_o == 4, "R1 reset code", div_code_o, 4);
        rst_n = 1;
    endtask

    task automatic probe(input int cp);
        engine(cp, 0);
        chk(seen_code == 4, "R2 probe code", seen_code, 4);
        chk(seen_len == 8 && seen_gl == 8, "R2 probe gate", seen_gl, 8);
        chk(res_stb_o == 0, "R2 no result after probe", res_stb_o, 0);
        exp_code = model_pick(cp);
        exp_ok = 0;
        chk(div_code_o == exp_code, "R3 probe pick", div_code_o, exp_code);
    endtask

    task automatic measure(input int c, input bit glitch);
        int nc;
        engine(c, glitch);
        chk(seen_code == exp_code, "R4 code used", seen_code, exp_code);
        chk(seen_len == 64 && seen_gl == 64, "R7 full gate", seen_gl, 64);
        if (glitch) chk(!stb_in_gate, "R8 done in gate ignored", stb_in_gate, 0);
        chk(res_stb_o == 1, "R5 strobe", res_stb_o, 1);
        chk(res_val_o == 16'(c << exp_code), "R5 scaled value", res_val_o, c << exp_code);
        chk(res_ok_o == exp_ok, "R6 ok flag", res_ok_o, exp_ok);
        nc = model_step(exp_code, c);
        exp_ok = (nc == exp_code);
        exp_code = nc;
        chk(div_code_o == exp_code, "R4 next code", div_code_o, exp_code);
        @(negedge clk);
        chk(res_stb_o == 0, "R5 strobe one cycle", res_stb_o, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset;
        probe(0);           // R3 zero probe picks code 0
        measure(511, 0);    // R4 clamp at 0, R6 first after probe
        measure(100, 0);
        measure(3585, 0);   // R4 step up
        measure(3584, 0);   // R4 boundary holds
        measure(512, 0);
        measure(511, 0);    // R4 step down
        measure(2000, 1);   // R8 glitch inside gate
        do_reset;
        probe(4095);        // R3 none qualifies
        measure(4095, 0);   // R4 clamp at 4
        measure(4095, 0);
        do_reset;
        probe(28);          // R3 boundary: code 0
        do_reset;
        probe(29);          // R3 boundary: code 1
        for (int i = 0; i < 150; i++) begin
            int sel = $urandom_range(0, 3);
            int c;
            case (sel)
                0: c = $urandom_range(0, 600);
                1: c = $urandom_range(3500, 4095);
                default: c = $urandom_range(0, 4095);
            endcase
            measure(c, ($urandom_range(0, 7) == 0));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule